// File: doc/BRIEF.md
# Privileged Status Register Unit

This block keeps a 16-bit processor status word made of two bytes: a low byte of arithmetic condition flags that any code may touch, and a high byte of control state (interrupt mask, supervisor flag, trace flag) that only supervisor code may touch. Each request selects one operation: load, read, AND with an immediate, OR with an immediate, or XOR with an immediate. Each request aims either at the flag byte alone or at the whole word.

Before each request is carried out, the unit checks the privilege level, which is the supervisor flag of the current word. A whole-word request made in user state is refused. The word stays as it is and a one-cycle trap request goes out to the exception logic. That logic, instruction decode and operand fetch sit outside this block.

Top module: `psw_ctrl_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, the status word is 0x2700: supervisor flag (bit 13) set, interrupt mask (bits 10:8) equal to 7, trace (bit 15) clear, flags clear. The trap output is 0 and the read bus is 0.
- R2: A load (op code 0) aimed at the flag byte (target 0) writes operand bits 7:0 into status bits 7:0 in the next cycle. The upper byte does not change. This works in both privilege states.
- R3: AND (op code 2), OR (op code 3) and XOR (op code 4) aimed at the flag byte combine status bits 7:0 with operand bits 7:0. The upper byte does not change. These work in both privilege states.
- R4: A read (op code 1) aimed at the flag byte puts {8'h00, status[7:0]} on the read bus in the next cycle, in either privilege state. The bus holds that value until the next granted read.
- R5: In supervisor state, load, AND, OR and XOR aimed at the whole word (target 1) apply to all 16 bits in the next cycle. This includes clearing bit 13, which drops the unit into user state.
- R6: In supervisor state, a whole-word read puts the full status word on the read bus in the next cycle.
- R7: In user state (bit 13 clear), any of the five operations aimed at the whole word leaves the status word and the read bus unchanged. The trap output is 1 in the next cycle.
- R8: Status bits 7:5, 12:11 and 14 are not implemented. They always read 0 and ignore every write.
- R9: A cycle with the valid strobe low, or with a reserved op code (5 to 7), changes neither the status word nor the read bus, and does not raise the trap.
- R10: The trap output is 1 only in the cycle right after a refused request. A single refused request followed by idle cycles gives a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request strobe for this cycle |
| op_code | input | 3 | 0 load, 1 read, 2 AND, 3 OR, 4 XOR, 5-7 reserved |
| op_target | input | 1 | 0 flag byte, 1 whole status word |
| op_operand | input | 16 | Immediate or register operand |
| psw_o | output | 16 | Current status word |
| rd_data_o | output | 16 | Result of the last granted read |
| trap_o | output | 1 | One-cycle privilege-violation trap request |

## Verification
The bench uses the default parameters: a 16-bit word with implemented-bit mask 0xA71F and reset value 0x2700. These defaults give a supervisor start from which a whole-word XOR clears bit 13, so the refused path in user state can be reached without a second reset. A scripted sequence with hand-computed words covers the byte merge, the masking of unimplemented bits, refused loads and reads, and reserved codes. After that comes a long random run in which a behavioural model and the unit move in step, with resets between phases that return the unit to supervisor state.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int PSW_W    = 16;
    localparam int LANE_W   = 8;
    localparam int NUM_LANE = PSW_W / LANE_W;
    localparam int CC_LANES = 1;
    localparam int OPC_W    = 3;
    localparam int SUP_BIT  = 13;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD = 3'd0,
        OPC_READ = 3'd1,
        OPC_AND  = 3'd2,
        OPC_OR   = 3'd3,
        OPC_XOR  = 3'd4
    } psw_op_e;

    typedef struct packed {
        logic [PSW_W-1:0] psw;
        logic [PSW_W-1:0] rd_data;
        logic             trap;
    } psw_state_t;

endpackage

// File: rtl/psw_priv_check.sv
module psw_priv_check
    import psw_pkg::*;
(
    input  logic             req_valid,
    input  logic [OPC_W-1:0] req_code,
    input  logic             req_whole,
    input  logic             is_super,
    output logic             grant_mod,
    output logic             grant_read,
    output logic             deny
);
    logic known_op;
    logic is_read;
    logic allowed;

    always_comb begin
        known_op = 1'b0;
        is_read  = 1'b0;
        case (psw_op_e'(req_code))
            OPC_LOAD, OPC_AND, OPC_OR, OPC_XOR: known_op = 1'b1;
            OPC_READ: begin
                known_op = 1'b1;
                is_read  = 1'b1;
            end
            default: known_op = 1'b0;
        endcase
        allowed    = is_super || !req_whole;
        grant_mod  = req_valid && known_op && allowed && !is_read;
        grant_read = req_valid && known_op && allowed && is_read;
        deny       = req_valid && known_op && !allowed;
    end

endmodule

// File: rtl/psw_logic_unit.sv
module psw_logic_unit
    import psw_pkg::*;
#(
    parameter logic [PSW_W-1:0] IMPL_MASK = 16'hA71F
) (
    input  logic [OPC_W-1:0] op_code,
    input  logic             whole,
    input  logic [PSW_W-1:0] cur,
    input  logic [PSW_W-1:0] operand,
    output logic [PSW_W-1:0] result
);
    logic [PSW_W-1:0] raw;

    for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
        logic              lane_en;
        logic [LANE_W-1:0] a;
        logic [LANE_W-1:0] b;
        logic [LANE_W-1:0] r;

        assign lane_en = whole || (g < CC_LANES);
        assign a       = cur[g*LANE_W +: LANE_W];
        assign b       = operand[g*LANE_W +: LANE_W];

        always_comb begin
            case (psw_op_e'(op_code))
                OPC_LOAD: r = b;
                OPC_AND:  r = a & b;
                OPC_OR:   r = a | b;
                OPC_XOR:  r = a ^ b;
                default:  r = a;
            endcase
        end

        assign raw[g*LANE_W +: LANE_W] = lane_en ? r : a;
    end

    assign result = raw & IMPL_MASK;

endmodule

// File: rtl/psw_ctrl_unit.sv
module psw_ctrl_unit
    import psw_pkg::*;
#(
    parameter logic [PSW_W-1:0] IMPL_MASK = 16'hA71F,
    parameter logic [PSW_W-1:0] RESET_VAL = 16'h2700
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    input  logic             op_target,
    input  logic [PSW_W-1:0] op_operand,
    output logic [PSW_W-1:0] psw_o,
    output logic [PSW_W-1:0] rd_data_o,
    output logic             trap_o
);
    localparam logic [PSW_W-1:0] CC_MASK = {{(PSW_W-LANE_W*CC_LANES){1'b0}},
                                            {(LANE_W*CC_LANES){1'b1}}};

    psw_state_t st_d, st_q;
    logic             grant_mod, grant_read, deny;
    logic [PSW_W-1:0] alu_res;

    psw_priv_check u_priv (
        .req_valid (op_valid),
        .req_code  (op_code),
        .req_whole (op_target),
        .is_super  (st_q.psw[SUP_BIT]),
        .grant_mod (grant_mod),
        .grant_read(grant_read),
        .deny      (deny)
    );

    psw_logic_unit #(.IMPL_MASK(IMPL_MASK)) u_alu (
        .op_code(op_code),
        .whole  (op_target),
        .cur    (st_q.psw),
        .operand(op_operand),
        .result (alu_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = deny;
        if (grant_mod) begin
            st_d.psw = alu_res;
        end
        if (grant_read) begin
            st_d.rd_data = op_target ? st_q.psw : (st_q.psw & CC_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.psw     <= RESET_VAL & IMPL_MASK;
            st_q.rd_data <= '0;
            st_q.trap    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign psw_o     = st_q.psw;
    assign rd_data_o = st_q.rd_data;
    assign trap_o    = st_q.trap;

    AST_CC_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_target |=> psw_o[PSW_W-1:LANE_W] == $past(psw_o[PSW_W-1:LANE_W])); // R2
    AST_USER_WHOLE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_target && !psw_o[SUP_BIT] |=> $stable(psw_o) && $stable(rd_data_o)); // R7
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_o & ~IMPL_MASK) == '0); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(psw_o) && $stable(rd_data_o) && !trap_o); // R9
    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(op_valid && op_target && !psw_o[SUP_BIT] && (op_code <= 3'd4))); // R10

endmodule

// File: tb/psw_ctrl_unit_tb.sv
module psw_ctrl_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic        op_target = 1'b0;
    logic [15:0] op_operand = '0;
    logic [15:0] psw_o, rd_data_o;
    logic        trap_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] m_psw, m_rd;
    logic        m_trap;

    psw_ctrl_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_target(op_target), .op_operand(op_operand),
        .psw_o(psw_o), .rd_data_o(rd_data_o), .trap_o(trap_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(bit v, logic [2:0] c, bit t, logic [15:0] x);
        logic [15:0] full;
        m_trap = 0;
        if (!v || c > 3'd4) return;
        if (t && !m_psw[13]) begin
            m_trap = 1;
            return;
        end
        case (c)
            3'd0: full = x;
            3'd2: full = m_psw & x;
            3'd3: full = m_psw | x;
            3'd4: full = m_psw ^ x;
            default: full = m_psw;
        endcase
        if (c == 3'd1) m_rd = t ? m_psw : {8'h00, m_psw[7:0]};
        else if (t) m_psw = full & 16'hA71F;
        else m_psw = {m_psw[15:8], full[7:0] & 8'h1F};
    endtask

    task automatic step(string tag, bit v, logic [2:0] c, bit t, logic [15:0] x);
        op_valid = v; op_code = c; op_target = t; op_operand = x;
        model(v, c, t, x);
        @(negedge clk);
        chk(tag, "psw", psw_o, m_psw);
        chk(tag, "rd", rd_data_o, m_rd);
        chk(tag, "trap", {15'd0, trap_o}, {15'd0, m_trap});
        chk("R8", "unimpl", psw_o & 16'h58E0, 16'h0000);
    endtask

    task automatic do_reset();
        rst_n = 0; op_valid = 0;
        m_psw = 16'h2700; m_rd = 0; m_trap = 0;
        repeat (2) @(negedge clk);
        chk("R1", "psw in reset", psw_o, 16'h2700);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "psw", psw_o, 16'h2700);
        chk("R1", "rd", rd_data_o, 16'h0000);
        chk("R1", "trap", {15'd0, trap_o}, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        step("R2", 1, 3'd0, 0, 16'hFFFF); chk("R2", "load cc", psw_o, 16'h271F);
        step("R3", 1, 3'd2, 0, 16'h000A); chk("R3", "and cc", psw_o, 16'h270A);
        step("R3", 1, 3'd3, 0, 16'hFF11); chk("R3", "or cc", psw_o, 16'h271B);
        step("R3", 1, 3'd4, 0, 16'h0003); chk("R3", "xor cc", psw_o, 16'h2718);
        step("R4", 1, 3'd1, 0, 16'h0000); chk("R4", "read cc", rd_data_o, 16'h0018);
        step("R6", 1, 3'd1, 1, 16'h0000); chk("R6", "read word", rd_data_o, 16'h2718);
        step("R5", 1, 3'd3, 1, 16'h8000); chk("R5", "or word", psw_o, 16'hA718);
        step("R5", 1, 3'd2, 1, 16'hF8FF); chk("R5", "and word", psw_o, 16'hA018);
        step("R5", 1, 3'd4, 1, 16'hFFFF); chk("R5", "xor word to user", psw_o, 16'h0707);
        step("R7", 1, 3'd0, 1, 16'h2700); chk("R7", "load refused", psw_o, 16'h0707);
        chk("R7", "trap", {15'd0, trap_o}, 16'h0001);
        step("R10", 0, 3'd0, 1, 16'h2700); chk("R10", "trap drops", {15'd0, trap_o}, 16'h0000);
        step("R7", 1, 3'd1, 1, 16'h0000); chk("R7", "read refused", rd_data_o, 16'h2718);
        step("R2", 1, 3'd0, 0, 16'hFF05); chk("R2", "user load cc", psw_o, 16'h0705);
        step("R4", 1, 3'd1, 0, 16'h0000); chk("R4", "user read cc", rd_data_o, 16'h0005);
        step("R9", 1, 3'd5, 1, 16'hFFFF); chk("R9", "reserved code", psw_o, 16'h0705);
        chk("R9", "reserved no trap", {15'd0, trap_o}, 16'h0000);
        step("R9", 0, 3'd0, 0, 16'h0000); chk("R9", "idle", psw_o, 16'h0705);
        for (int ph = 0; ph < 4; ph++) begin
            do_reset();
            for (int i = 0; i < 600; i++) begin
                logic [2:0] c = 3'($urandom_range(0, 7));
                step("R5", ($urandom_range(0, 7) != 0), c, 1'($urandom),
                     16'($urandom));
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule